// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Software programs it through a small byte-wide register port. A control register holds the enable, start, auto-trigger, completion flag, interrupt enable and a 3-bit clock divider code. A configuration register holds the channel code, the reference code and the result justification bit. The analog multiplexer, reference and gain circuitry sit outside. They receive the channel and reference codes unchanged and sample on the `conv_busy` window.

The block divides the system clock by a power of two to form the converter clock. It then counts converter clocks through each conversion. The first conversion after the block is enabled is longer, to let the front end settle. At the end of the count the block latches the 10-bit `sample_data` word, sets the completion flag and raises the interrupt if that is allowed. The result is read as a high and a low byte, either left- or right-justified.

Register map (address on `bus_addr`):
- 0 control: [0] enable, [1] start (reads 1 while converting), [2] auto-trigger, [3] completion flag, [4] interrupt enable, [7:5] divider code.
- 1 configuration: [1:0] reference code, [2] justification, [7:3] channel code.
- 2 result high byte, 3 result low byte (read only).

`bus_rdata` is registered. It shows the register addressed one cycle earlier.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Divider code k in 1..7 makes one converter clock equal to 2^k system clocks. Code 0 is treated as /2. The converter clock restarts its phase at the clock edge that starts a conversion.
- R2: The first conversion after the enable bit (control bit 0) goes from 0 to 1 keeps `conv_busy` high for 25 converter clocks (25·2^k system cycles). The same applies to the first conversion after reset.
- R3: Every later conversion keeps `conv_busy` high for 13 converter clocks.
- R4: With justification bit (config bit 2) = 0, address 3 reads result[7:0] and address 2 reads {6'b0, result[9:8]}. With it = 1, address 2 reads result[9:2] and address 3 reads {result[1:0], 6'b0}. The bit acts on the stored result at read time.
- R5: A control write with bits 0 and 1 both set starts a conversion. A write with bit 1 set and bit 0 clear starts nothing. A start while a conversion runs neither restarts it nor stretches it.
- R6: The completion flag (control bit 3) is set when a result is latched. Writing 1 to bit 3 clears it, and writing 0 leaves it unchanged. `irq` is high exactly while the flag and the interrupt enable (control bit 4) are both 1.
- R7: Control bit 1 reads 1 while a conversion runs and 0 once the result is latched.
- R8: With auto-trigger (control bit 2) set, a rising edge on `ext_trig` starts a conversion if the block is enabled and idle. Edges while busy, or with bit 2 clear, start nothing.
- R9: Clearing the enable bit ends a running conversion at once, without setting the flag. The next conversion is again a 25-clock first conversion.
- R10: `chan_sel` follows config bits [7:3] and `ref_sel` follows config bits [1:0]. Both change from the clock edge after the write.
- R11: After reset, every register reads 0 and `irq` and `conv_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_trig | input | 1 | External conversion trigger |
| sample_data | input | 10 | Converter output word, latched at the end of a conversion |
| conv_busy | output | 1 | High while a conversion is in progress |
| chan_sel | output | 5 | Channel code to the analog multiplexer |
| ref_sel | output | 2 | Reference code to the analog reference |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 3-bit divider code, and conversion lengths of 25 and 13 converter clocks. The divider values are small, so both conversion lengths can be measured in exact system cycles, and the /128 setting still fits well inside the run. A scoreboard compares each measured busy window with the length expected from the divider and from whether the conversion is the first one. It also covers aborted conversions, the reserved divider code and ignored starts. Byte layouts are checked for both justifications on two different sample words.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_CFG = 2'd1;
  localparam logic [1:0] ADDR_RHI = 2'd2;
  localparam logic [1:0] ADDR_RLO = 2'd3;

  // control byte bit positions
  localparam int C_EN    = 0;
  localparam int C_START = 1;
  localparam int C_AUTO  = 2;
  localparam int C_FLAG  = 3;
  localparam int C_IE    = 4;
  localparam int C_PRE   = 5;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  // code 0 is reserved and falls back to the /2 setting
  always_comb begin
    if (sel == '0) last = DIV_W'(1);
    else           last = (DIV_W'(1) << sel) - DIV_W'(1);
    tick = run && (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0)); // R1
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick); // R1
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int FIRST_CYC = 25,
  parameter int NEXT_CYC  = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic fin
);
  localparam int CYC_W = $clog2(FIRST_CYC + 1);

  logic [CYC_W-1:0] cnt;
  logic [CYC_W-1:0] limit;
  logic             first_pend;

  always_comb begin
    limit = first_pend ? CYC_W'(FIRST_CYC - 1) : CYC_W'(NEXT_CYC - 1);
    fin   = busy && tick && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy       <= 1'b0;
      cnt        <= '0;
      first_pend <= 1'b1;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (fin) begin
      busy       <= 1'b0;
      cnt        <= '0;
      first_pend <= 1'b0;
    end else if (busy && tick) begin
      cnt <= cnt + CYC_W'(1);
    end
  end

  AST_FIN_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy); // R3
  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && first_pend)); // R9
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= limit)); // R2
  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && en) |-> $stable(first_pend)); // R2
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  raw,
  input  logic              left,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  always_comb begin
    if (left) pair = {raw, {PAD_W{1'b0}}};
    else      pair = {{PAD_W{1'b0}}, raw};
    hi = pair[PAIR_W-1:BYTE_W];
    lo = pair[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W     = 10,
  parameter int PRE_W     = 3,
  parameter int CH_W      = 5,
  parameter int REF_W     = 2,
  parameter int FIRST_CYC = 25,
  parameter int NEXT_CYC  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             ext_trig,
  input  logic [RES_W-1:0] sample_data,
  output logic             conv_busy,
  output logic [CH_W-1:0]  chan_sel,
  output logic [REF_W-1:0] ref_sel,
  output logic             irq
);
  import adc_seq_pkg::*;

  localparam int CFG_AL = REF_W;
  localparam int CFG_CH = REF_W + 1;

  logic             en_q, auto_q, flag_q, ie_q, align_q, trig_q;
  logic [PRE_W-1:0] pre_q;
  logic [CH_W-1:0]  chan_q;
  logic [REF_W-1:0] ref_q;
  logic [RES_W-1:0] raw_q;

  logic             wr_ctl, wr_cfg, en_next, sw_start, hw_start, start;
  logic             tick, busy, fin;
  logic [7:0]       res_hi, res_lo, rd_next;

  always_comb begin
    wr_ctl   = bus_wr && (bus_addr == ADDR_CTL);
    wr_cfg   = bus_wr && (bus_addr == ADDR_CFG);
    en_next  = wr_ctl ? bus_wdata[C_EN] : en_q;
    sw_start = wr_ctl && bus_wdata[C_EN] && bus_wdata[C_START];
    hw_start = auto_q && en_q && ext_trig && !trig_q;
    start    = sw_start || hw_start;
  end

  adc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(busy), .sel(pre_q), .tick(tick)
  );

  adc_conv_timer #(.FIRST_CYC(FIRST_CYC), .NEXT_CYC(NEXT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .en(en_next), .start(start), .tick(tick),
    .busy(busy), .fin(fin)
  );

  adc_result_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .raw(raw_q), .left(align_q), .hi(res_hi), .lo(res_lo)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTL: rd_next = 8'({pre_q, ie_q, flag_q, auto_q, busy, en_q});
      ADDR_CFG: rd_next = 8'({chan_q, align_q, ref_q});
      ADDR_RHI: rd_next = res_hi;
      default:  rd_next = res_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; auto_q <= 1'b0; flag_q <= 1'b0; ie_q <= 1'b0;
      pre_q <= '0; chan_q <= '0; align_q <= 1'b0; ref_q <= '0;
      raw_q <= '0; trig_q <= 1'b0; bus_rdata <= '0;
    end else begin
      trig_q    <= ext_trig;
      bus_rdata <= rd_next;
      if (wr_ctl) begin
        en_q   <= bus_wdata[C_EN];
        auto_q <= bus_wdata[C_AUTO];
        ie_q   <= bus_wdata[C_IE];
        pre_q  <= bus_wdata[C_PRE +: PRE_W];
      end
      if (fin)                          flag_q <= 1'b1;
      else if (wr_ctl && bus_wdata[C_FLAG]) flag_q <= 1'b0;
      if (wr_cfg) begin
        ref_q   <= bus_wdata[REF_W-1:0];
        align_q <= bus_wdata[CFG_AL];
        chan_q  <= bus_wdata[CFG_CH +: CH_W];
      end
      if (fin) raw_q <= sample_data;
    end
  end

  assign conv_busy = busy;
  assign chan_sel  = chan_q;
  assign ref_sel   = ref_q;
  assign irq       = flag_q && ie_q;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    fin |=> flag_q); // R6
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_busy) |-> en_q); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(raw_q)); // R4
  AST_NO_FLAG_WHEN_ABORTED: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !$past(fin)) |-> !$rose(flag_q)); // R9
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_trig = 1'b0;
  logic [9:0] sample_data = 10'd0;
  logic       conv_busy;
  logic [4:0] chan_sel;
  logic [1:0] ref_sel;
  logic       irq;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int run_len = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .sample_data(sample_data), .conv_busy(conv_busy), .chan_sel(chan_sel),
    .ref_sel(ref_sel), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input int pre, input bit ie, input bit clr,
                                     input bit aut, input bit st, input bit en);
    return {3'(pre), ie, clr, aut, st, en};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    while (conv_busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures each busy window and pops the expected length
  initial begin
    forever begin
      @(negedge clk);
      if (conv_busy) run_len++;
      else if (run_len != 0) begin
        if (exp_q.size() == 0) chk("scoreboard unexpected conversion R5", run_len, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e >= 0) chk("conversion length R1/R2/R3", run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    rd(2'd0, v); chk("R11 control reset", v, 0);
    rd(2'd1, v); chk("R11 config reset", v, 0);
    chk("R11 irq reset", int'(irq), 0);
    chk("R11 busy reset", int'(conv_busy), 0);

    // R10 pass-through
    wr(2'd1, 8'h9B);
    chk("R10 chan_sel", int'(chan_sel), 8'h13);
    chk("R10 ref_sel", int'(ref_sel), 3);

    // R2 first conversion, /2
    sample_data = 10'h2A5;
    exp_q.push_back(50);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 1));
    rd(2'd0, v); chk("R7 start reads 1 while busy", v, 8'h23);
    wait_idle();
    sample_data = 10'h000;
    rd(2'd0, v); chk("R6 R7 flag set start clear", v, 8'h29);
    chk("R6 irq masked", int'(irq), 0);
    rd(2'd2, v); chk("R4 right hi", v, 8'h02);
    rd(2'd3, v); chk("R4 right lo", v, 8'hA5);
    wr(2'd1, 8'h9F);
    rd(2'd2, v); chk("R4 left hi", v, 8'hA9);
    rd(2'd3, v); chk("R4 left lo", v, 8'h40);

    // R6 flag write semantics
    wr(2'd0, ctl(1, 0, 0, 0, 0, 1));
    rd(2'd0, v); chk("R6 write 0 keeps flag", v, 8'h29);
    wr(2'd0, ctl(1, 0, 1, 0, 0, 1));
    rd(2'd0, v); chk("R6 write 1 clears flag", v, 8'h21);

    // R3 later conversion, /4, interrupt enabled
    sample_data = 10'h155;
    exp_q.push_back(52);
    wr(2'd0, ctl(2, 1, 0, 0, 1, 1));
    chk("R6 irq low while converting", int'(irq), 0);
    wait_idle();
    chk("R6 irq raised", int'(irq), 1);
    rd(2'd2, v); chk("R4 left hi second word", v, 8'h55);
    rd(2'd3, v); chk("R4 left lo second word", v, 8'h40);
    wr(2'd0, ctl(2, 1, 1, 0, 0, 1));
    chk("R6 irq cleared", int'(irq), 0);

    // R5 start while busy is ignored
    exp_q.push_back(26);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 1));
    repeat (3) @(negedge clk);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 1));
    wait_idle();
    wr(2'd0, ctl(1, 0, 1, 0, 0, 1));

    // R5 start without enable
    wr(2'd0, ctl(1, 0, 0, 0, 1, 0));
    chk("R5 start ignored when disabled", int'(conv_busy), 0);
    repeat (2) @(negedge clk);
    chk("R5 still idle", int'(conv_busy), 0);

    // R9 abort, then first conversion again
    exp_q.push_back(-1);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 1));
    repeat (10) @(negedge clk);
    wr(2'd0, ctl(1, 0, 0, 0, 0, 0));
    chk("R9 abort stops busy", int'(conv_busy), 0);
    rd(2'd0, v); chk("R9 abort leaves flag clear", v, 8'h20);
    exp_q.push_back(50);
    wr(2'd0, ctl(1, 0, 0, 0, 1, 1));
    wait_idle();
    wr(2'd0, ctl(1, 0, 1, 0, 0, 1));

    // R8 trigger ignored without auto-trigger
    @(negedge clk); ext_trig = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 trigger ignored when auto off", int'(conv_busy), 0);
    ext_trig = 1'b0;

    // R8 auto-trigger with reserved divider code (R1: acts as /2)
    wr(2'd0, ctl(0, 0, 0, 1, 0, 1));
    exp_q.push_back(26);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk);
    chk("R8 trigger starts conversion", int'(conv_busy), 1);
    repeat (3) @(negedge clk); ext_trig = 1'b0;
    repeat (2) @(negedge clk); ext_trig = 1'b1;
    wait_idle();
    ext_trig = 1'b0;
    rd(2'd0, v); chk("R8 flag after triggered run", v, 8'h0D);

    // R1 largest divider
    wr(2'd0, ctl(7, 0, 1, 0, 0, 1));
    exp_q.push_back(13 * 128);
    wr(2'd0, ctl(7, 0, 0, 0, 1, 1));
    wait_idle();
    repeat (2) @(negedge clk);
    chk("scoreboard drained R3", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R11: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule